// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

This block is the configuration front end of a Super I/O style peripheral. It sits on a byte-wide I/O bus and claims two adjacent addresses: an index port at the base address and a data port at base+1. After reset it is locked. In that state it only watches byte writes to the index port for a four-byte unlock key. The final key byte depends on which of the two supported base addresses the instance is built for.

Once unlocked, software writes a register number to the index port and then reads or writes that register through the data port. The register set has four parts. There is a read-only 16-bit chip identifier. There is a logical-device selector. There is a global flash-control register, which drives segment enables, a host write enable and a pin-assignment select. Each logical device also has its own 16-bit I/O base pair. The base pair of the flash logical device is presented on output pins. Writing a fixed exit command through the index/data pair locks the port again. All register contents are kept across the relock.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_unlocked`=0), all flash outputs are zero, and every read returns 0xFF while locked.
- R2: Four consecutive writes to the base port of 0x87, 0x01, 0x55 and the final key byte set `cfg_unlocked` on the clock edge that takes the fourth write; after only three bytes it stays locked.
- R3: The final key byte is 0x55 when BASE_PORT is 0x2E and 0xAA when BASE_PORT is 0x4E; the other value does not unlock.
- R4: A base-port write that does not match the expected key byte returns the detector to its first step, except that 0x87 places it at the second step (0x87 already counted).
- R5: While locked, writes to the data port and non-key writes to the index port change no register: after unlocking, the index reads 0x00 and register 0x24 reads 0x00.
- R6: Index 0x20 reads CHIP_ID[15:8] (default 0x87) and index 0x21 reads CHIP_ID[7:0] (default 0x16); writes to them have no effect.
- R7: Index 0x07 is a readable and writable 8-bit logical-device number. Indexes 0x64 (high byte) and 0x65 (low byte) access a base pair banked per device 0..NUM_LDN-1. Devices at or above NUM_LDN read 0 and ignore writes. `flash_io_base` shows the pair of device FLASH_LDN (default 7).
- R8: Index 0x24 is one global register that reads the same under any device: only bits 1..5 are stored, and bits 0, 6 and 7 read 0. `flash_seg_en` is bits 3:1, `flash_host_wr_en` is bit 4 and `flash_pin_alt` is bit 5.
- R9: Writing 0x02 to index 0x02 locks the port on that clock edge; any other value written there has no effect. After the relock the key is needed again, and register contents are kept.
- R10: When unlocked, a read of the index port returns the current index. A read of the data port at an unimplemented index (including 0x02) returns 0x00, and writes to such an index are ignored.
- R11: `io_rdata` is combinational: a read and a write of the same data register in the same cycle return the old value, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| cfg_unlocked | output | 1 | High while configuration access is open |
| flash_io_base | output | 16 | Base pair of the flash logical device |
| flash_seg_en | output | 3 | Flash segment enables (register 0x24 bits 3:1) |
| flash_host_wr_en | output | 1 | Host write enable to flash (bit 4) |
| flash_pin_alt | output | 1 | Alternate flash pin assignment (bit 5) |

## Verification
A read and a write of the same data register can fall in the same cycle, and the exit write can coincide with a data-port read. The bench raises both strobes together on a banked base register that already holds a known value. It expects the old byte during that cycle and the new byte, together with the updated `flash_io_base`, one cycle later. The exit write is issued with the read strobe high. The read must return 0x00 for register 0x02, and `cfg_unlocked` must fall at the same edge that takes the write.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // Indexed register numbers
    localparam logic [7:0] IDX_EXIT     = 8'h02;
    localparam logic [7:0] IDX_LDN      = 8'h07;
    localparam logic [7:0] IDX_ID_HI    = 8'h20;
    localparam logic [7:0] IDX_ID_LO    = 8'h21;
    localparam logic [7:0] IDX_FCTL     = 8'h24;
    localparam logic [7:0] IDX_FBASE_HI = 8'h64;
    localparam logic [7:0] IDX_FBASE_LO = 8'h65;

    // Exit command value and the fixed part of the unlock key
    localparam logic [7:0] EXIT_CMD  = 8'h02;
    localparam logic [7:0] KEY_B0    = 8'h87;
    localparam logic [7:0] KEY_B1    = 8'h01;
    localparam logic [7:0] KEY_B2    = 8'h55;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_GOT1 = 2'd1,
        KS_GOT2 = 2'd2,
        KS_GOT3 = 2'd3
    } key_step_e;

endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] KEY_LAST = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       relock,
    output logic       unlocked
);

    typedef struct packed {
        key_step_e step;
        logic      open;
    } key_state_t;

    key_state_t st_d, st_q;
    key_step_e  restart;

    // A byte that breaks the sequence may itself be a first key byte
    assign restart = (key_byte == KEY_B0) ? KS_GOT1 : KS_IDLE;

    always_comb begin
        st_d = st_q;
        if (relock) begin
            st_d.step = KS_IDLE;
            st_d.open = 1'b0;
        end else if (!st_q.open && key_wr) begin
            unique case (st_q.step)
                KS_IDLE: st_d.step = restart;
                KS_GOT1: st_d.step = (key_byte == KEY_B1) ? KS_GOT2 : restart;
                KS_GOT2: st_d.step = (key_byte == KEY_B2) ? KS_GOT3 : restart;
                KS_GOT3: begin
                    if (key_byte == KEY_LAST) begin
                        st_d.open = 1'b1;
                        st_d.step = KS_IDLE;
                    end else begin
                        st_d.step = restart;
                    end
                end
                default: st_d.step = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{step: KS_IDLE, open: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked = st_q.open;

    // R4: a stray 0x87 while locked always leaves the detector at step two
    assert_restart_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.open && key_wr && !relock && key_byte == KEY_B0) |=> (st_q.step == KS_GOT1));

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter int          NUM_LDN   = 8,
    parameter int          FLASH_LDN = 7,
    parameter logic [7:0]  FCTL_MASK = 8'h3E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        unlocked_i,
    input  logic        idx_wr,
    input  logic        data_wr,
    input  logic [7:0]  wdata,
    output logic [7:0]  index_o,
    output logic [7:0]  rd_data_o,
    output logic        exit_o,
    output logic [15:0] flash_base_o,
    output logic [7:0]  fctl_o
);

    // NUM_LDN must lie in 2..256
    localparam int         LDN_W     = $clog2(NUM_LDN);
    localparam logic [7:0] LDN_LIMIT = 8'(NUM_LDN - 1);

    typedef struct packed {
        logic [7:0]                    idx;
        logic [7:0]                    ldn;
        logic [7:0]                    fctl;
        logic [NUM_LDN-1:0][15:0]      base;
    } cfg_regs_t;

    cfg_regs_t          r_d, r_q;
    logic [LDN_W-1:0]   sel;
    logic               ldn_ok;

    assign sel    = r_q.ldn[LDN_W-1:0];
    assign ldn_ok = (r_q.ldn <= LDN_LIMIT);

    always_comb begin
        r_d = r_q;
        if (unlocked_i) begin
            if (idx_wr) begin
                r_d.idx = wdata;
            end
            if (data_wr) begin
                case (r_q.idx)
                    IDX_LDN:      r_d.ldn  = wdata;
                    IDX_FCTL:     r_d.fctl = wdata & FCTL_MASK;
                    IDX_FBASE_HI: if (ldn_ok) r_d.base[sel][15:8] = wdata;
                    IDX_FBASE_LO: if (ldn_ok) r_d.base[sel][7:0]  = wdata;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.idx)
            IDX_ID_HI:    rd_data_o = CHIP_ID[15:8];
            IDX_ID_LO:    rd_data_o = CHIP_ID[7:0];
            IDX_LDN:      rd_data_o = r_q.ldn;
            IDX_FCTL:     rd_data_o = r_q.fctl;
            IDX_FBASE_HI: rd_data_o = ldn_ok ? r_q.base[sel][15:8] : 8'h00;
            IDX_FBASE_LO: rd_data_o = ldn_ok ? r_q.base[sel][7:0]  : 8'h00;
            default:      rd_data_o = 8'h00;
        endcase
    end

    assign exit_o       = unlocked_i && data_wr && (r_q.idx == IDX_EXIT) && (wdata == EXIT_CMD);
    assign index_o      = r_q.idx;
    assign fctl_o       = r_q.fctl;
    assign flash_base_o = r_q.base[FLASH_LDN];

    // R5: nothing moves while the port is locked
    assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked_i |=> ($stable(r_q.idx) && $stable(r_q.ldn) && $stable(r_q.fctl) && $stable(r_q.base)));

    // R7: a high-byte write under the flash device lands on the output pins
    assert_flash_base_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked_i && data_wr && r_q.idx == IDX_FBASE_HI && r_q.ldn == 8'(FLASH_LDN))
        |=> (flash_base_o[15:8] == $past(wdata)));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] BASE_PORT = 16'h002E,
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter int          NUM_LDN   = 8,
    parameter int          FLASH_LDN = 7,
    parameter logic [7:0]  FCTL_MASK = 8'h3E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        cfg_unlocked,
    output logic [15:0] flash_io_base,
    output logic [2:0]  flash_seg_en,
    output logic        flash_host_wr_en,
    output logic        flash_pin_alt
);

    localparam logic [15:0] DATA_PORT = BASE_PORT + 16'd1;
    localparam logic [7:0]  KEY_LAST  = (BASE_PORT == 16'h004E) ? 8'hAA : 8'h55;

    logic       hit_idx, hit_data;
    logic       key_wr, idx_wr, data_wr;
    logic       relock;
    logic [7:0] cur_idx, reg_rdata, fctl;

    assign hit_idx  = (io_addr == BASE_PORT);
    assign hit_data = (io_addr == DATA_PORT);
    assign key_wr   = io_wr && hit_idx && !cfg_unlocked;
    assign idx_wr   = io_wr && hit_idx && cfg_unlocked;
    assign data_wr  = io_wr && hit_data && cfg_unlocked;

    sio_key_fsm #(
        .KEY_LAST (KEY_LAST)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (io_wdata),
        .relock   (relock),
        .unlocked (cfg_unlocked)
    );

    sio_cfg_regs #(
        .CHIP_ID   (CHIP_ID),
        .NUM_LDN   (NUM_LDN),
        .FLASH_LDN (FLASH_LDN),
        .FCTL_MASK (FCTL_MASK)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .unlocked_i   (cfg_unlocked),
        .idx_wr       (idx_wr),
        .data_wr      (data_wr),
        .wdata        (io_wdata),
        .index_o      (cur_idx),
        .rd_data_o    (reg_rdata),
        .exit_o       (relock),
        .flash_base_o (flash_io_base),
        .fctl_o       (fctl)
    );

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && cfg_unlocked) begin
            if (hit_idx) begin
                io_rdata = cur_idx;
            end else if (hit_data) begin
                io_rdata = reg_rdata;
            end
        end
    end

    assign flash_seg_en     = fctl[3:1];
    assign flash_host_wr_en = fctl[4];
    assign flash_pin_alt    = fctl[5];

    // R2: the port only opens on the edge that takes the last key byte
    assert_unlock_on_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_unlocked) |-> $past(io_wr && hit_idx && io_wdata == KEY_LAST));

    // R9: the exit command closes the port at once
    assert_exit_relocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_wr && hit_data && cur_idx == IDX_EXIT && io_wdata == EXIT_CMD)
        |=> !cfg_unlocked);

endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  rdata_main, rdata_alt;
    logic        unl_main, unl_alt;
    logic [15:0] fbase_main, fbase_alt;
    logic [2:0]  seg_main, seg_alt;
    logic        hw_main, hw_alt, pin_main, pin_alt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sio_cfg_port #(.BASE_PORT(16'h002E)) u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_main), .cfg_unlocked(unl_main),
        .flash_io_base(fbase_main), .flash_seg_en(seg_main),
        .flash_host_wr_en(hw_main), .flash_pin_alt(pin_main));

    sio_cfg_port #(.BASE_PORT(16'h004E)) u_alt (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rdata_alt), .cfg_unlocked(unl_alt),
        .flash_io_base(fbase_alt), .flash_seg_en(seg_alt),
        .flash_host_wr_en(hw_alt), .flash_pin_alt(pin_alt));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        d = (a[15:4] == 12'h004 && a[3:0] >= 4'hE) ? rdata_alt : rdata_main;
        io_rd = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] v);
        wr(16'h002E, idx);
        wr(16'h002F, v);
    endtask

    task automatic get_reg(input logic [7:0] idx, output logic [7:0] v);
        wr(16'h002E, idx);
        rd(16'h002F, v);
    endtask

    task automatic unlock_main();
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01);
        wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
    endtask

    task automatic lock_main();
        set_reg(8'h02, 8'h02);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 unlocked after reset", unl_main, 0);
        chk("R1 flash base after reset", fbase_main, 0);
        chk("R1 flash ctl outputs after reset", {pin_main, hw_main, seg_main}, 0);
        rd(16'h002F, v);
        chk("R1 locked data read", v, 8'hFF);
        rd(16'h002E, v);
        chk("R1 locked index read", v, 8'hFF);
    endtask

    task automatic t_locked_ignore();
        logic [7:0] v;
        wr(16'h002F, 8'h24);
        wr(16'h002E, 8'h24);
        wr(16'h002F, 8'hFF);
        unlock_main();
        rd(16'h002E, v);
        chk("R5 index untouched while locked", v, 8'h00);
        get_reg(8'h24, v);
        chk("R5 flash ctl untouched while locked", v, 8'h00);
        chk("R5 outputs untouched", {pin_main, hw_main, seg_main}, 0);
        lock_main();
    endtask

    task automatic t_unlock();
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55);
        chk("R2 locked after three key bytes", unl_main, 0);
        wr(16'h002E, 8'h55);
        chk("R2 unlocked after fourth key byte", unl_main, 1);
        lock_main();
    endtask

    task automatic t_key_by_base();
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'hAA);
        chk("R3 0xAA rejected at base 0x2E", unl_main, 0);
        wr(16'h004E, 8'h87); wr(16'h004E, 8'h01); wr(16'h004E, 8'h55); wr(16'h004E, 8'h55);
        chk("R3 0x55 rejected at base 0x4E", unl_alt, 0);
        wr(16'h004E, 8'h87); wr(16'h004E, 8'h01); wr(16'h004E, 8'h55); wr(16'h004E, 8'hAA);
        chk("R3 0xAA accepted at base 0x4E", unl_alt, 1);
        chk("R3 main port unaffected", unl_main, 0);
        wr(16'h004E, 8'h02); wr(16'h004F, 8'h02);
        chk("R3 alt port relocked", unl_alt, 0);
    endtask

    task automatic t_key_restart();
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h00);
        wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
        chk("R4 broken sequence stays locked", unl_main, 0);
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h87);
        wr(16'h002E, 8'h01); wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
        chk("R4 0x87 mid-sequence restarts at step two", unl_main, 1);
        lock_main();
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h87); wr(16'h002E, 8'h01);
        wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
        chk("R4 repeated 0x87 accepted", unl_main, 1);
        lock_main();
    endtask

    task automatic t_id();
        logic [7:0] v;
        unlock_main();
        get_reg(8'h20, v);
        chk("R6 id high byte", v, 8'h87);
        get_reg(8'h21, v);
        chk("R6 id low byte", v, 8'h16);
        set_reg(8'h20, 8'h00);
        get_reg(8'h20, v);
        chk("R6 id read-only", v, 8'h87);
    endtask

    task automatic t_banks();
        logic [7:0] v;
        set_reg(8'h07, 8'h07);
        set_reg(8'h64, 8'h0A);
        set_reg(8'h65, 8'h20);
        chk("R7 flash base pins", fbase_main, 16'h0A20);
        get_reg(8'h64, v);
        chk("R7 read back high byte", v, 8'h0A);
        set_reg(8'h07, 8'h03);
        set_reg(8'h64, 8'h55);
        get_reg(8'h64, v);
        chk("R7 device 3 bank", v, 8'h55);
        chk("R7 flash pins unaffected by device 3", fbase_main, 16'h0A20);
        set_reg(8'h07, 8'h20);
        set_reg(8'h64, 8'h77);
        get_reg(8'h64, v);
        chk("R7 out-of-range device reads zero", v, 8'h00);
        get_reg(8'h07, v);
        chk("R7 device select read back", v, 8'h20);
        set_reg(8'h07, 8'h07);
        get_reg(8'h64, v);
        chk("R7 device 7 bank kept", v, 8'h0A);
        get_reg(8'h65, v);
        chk("R7 device 7 low byte kept", v, 8'h20);
    endtask

    task automatic t_fctl();
        logic [7:0] v;
        set_reg(8'h24, 8'hFF);
        get_reg(8'h24, v);
        chk("R8 only bits 1..5 stored", v, 8'h3E);
        chk("R8 all flash ctl outputs high", {pin_main, hw_main, seg_main}, 5'b11111);
        set_reg(8'h07, 8'h03);
        get_reg(8'h24, v);
        chk("R8 global under other device", v, 8'h3E);
        set_reg(8'h24, 8'h0A);
        chk("R8 segment enables", seg_main, 3'b101);
        chk("R8 host write and pin select low", {pin_main, hw_main}, 0);
        set_reg(8'h07, 8'h07);
    endtask

    task automatic t_index();
        logic [7:0] v;
        wr(16'h002E, 8'h65);
        rd(16'h002E, v);
        chk("R10 index port read", v, 8'h65);
        set_reg(8'h30, 8'h5A);
        get_reg(8'h30, v);
        chk("R10 unimplemented index reads zero", v, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        wr(16'h002E, 8'h64);
        @(negedge clk);
        io_addr = 16'h002F; io_wdata = 8'hC3; io_wr = 1'b1; io_rd = 1'b1;
        #2;
        chk("R11 same-cycle read returns old value", rdata_main, 8'h0A);
        @(negedge clk);
        io_wr = 1'b0;
        #2;
        chk("R11 new value next cycle", rdata_main, 8'hC3);
        io_rd = 1'b0;
        chk("R11 flash pins updated", fbase_main, 16'hC320);
    endtask

    task automatic t_exit();
        logic [7:0] v;
        set_reg(8'h02, 8'h01);
        chk("R9 other value does not relock", unl_main, 1);
        get_reg(8'h02, v);
        chk("R10 exit index reads zero", v, 8'h00);
        wr(16'h002E, 8'h02);
        @(negedge clk);
        io_addr = 16'h002F; io_wdata = 8'h02; io_wr = 1'b1; io_rd = 1'b1;
        #2;
        chk("R9 read during exit write", rdata_main, 8'h00);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        chk("R9 exit relocks", unl_main, 0);
        rd(16'h002F, v);
        chk("R9 locked read after exit", v, 8'hFF);
        wr(16'h002F, 8'h00);
        chk("R9 settings kept after relock", fbase_main, 16'hC320);
        unlock_main();
        chk("R9 key needed again and accepted", unl_main, 1);
        get_reg(8'h24, v);
        chk("R9 flash ctl kept", v, 8'h0A);
        lock_main();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked_ignore();
        t_unlock();
        t_key_by_base();
        t_key_restart();
        t_id();
        t_banks();
        t_fctl();
        t_index();
        t_same_cycle();
        t_exit();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule